// File: doc/BRIEF.md
# Asynchronous SRAM Pin-Level Target Model

This block stands in for a 16-bit word-organised asynchronous static RAM when a memory controller is verified or prototyped. It runs on a fast model clock, samples the device-side strobes, address and write data on every edge, and turns them into one of four modes: standby, selected with outputs disabled, read, or write. Reads place stored data on a registered 16-bit output with one output-enable per byte lane, so a board-level or testbench tristate can drive each lane on its own.

Writes take effect when the overlap of chip select, a byte enable and the write strobe ends. The word is stored using the address, data and lane enables of the last sample inside that overlap. A write strobe always wins over the output enable. A small timing monitor counts samples and raises one-cycle flags when the controller breaks minimum pulse, setup or cycle times, or moves the address in the middle of a write. A parameter picks either the two-select pinout or the single-select pinout.

Top module: `async_sram_model`

## Requirements
- R1: The model is in standby when `cs_n` is 1, or `cs_hi` is 0 (two-select variant), or both bits of `be_n` are 1; `dout_en` is then 2'b00 one cycle after that sample.
- R2: When selected with `we_n` at 0, `dout_en` is 2'b00 one cycle later, whatever the level of `oe_n`.
- R3: When selected with `we_n` at 1 and `oe_n` at 0, one cycle later `dout_en[0]` (bits 7:0) is the inverse of `be_n[0]` and `dout_en[1]` (bits 15:8) is the inverse of `be_n[1]`, and each enabled lane of `dout` carries the stored word at the sampled address.
- R4: When selected with `we_n` and `oe_n` both at 1, `dout_en` is 2'b00 one cycle later.
- R5: A write stores bits 7:0 only if `be_n[0]` was 0 and bits 15:8 only if `be_n[1]` was 0; a lane not enabled keeps its previous contents.
- R6: A write commits at the first sample where the overlap is false, using the address, data and lane enables of the preceding sample; a read sampled on that same edge returns the old contents, and a read on the next sample returns the new ones.
- R7: With `DUAL_CS` set to 0, `cs_hi` is ignored and `cs_n` alone selects the device.
- R8: `viol_wpulse` pulses one cycle after a commit edge if the overlap lasted fewer than `TWP_MIN` samples.
- R9: `viol_dsetup` pulses one cycle after a commit edge if the committed data had been stable for fewer than `TDS_MIN` samples, counting the last overlap sample.
- R10: `viol_rcycle` pulses one cycle after a sample where the address changes between two consecutive read-mode samples (read or output-disabled) and the old address had been held fewer than `TRC_MIN` samples.
- R11: `viol_addr` pulses one cycle after a sample where the overlap is active on this and the previous sample and the address differs between them.
- R12: A synchronous reset clears `dout_en` and all violation flags on the next cycle and cancels any pending commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select (ignored when DUAL_CS is 0) |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| be_n | input | DATA_W/8 | Active-low byte-lane enables, bit 0 for bits 7:0 |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the controller |
| dout | output | DATA_W | Registered read data |
| dout_en | output | DATA_W/8 | Registered per-lane output enables |
| viol_wpulse | output | 1 | Short write overlap pulse |
| viol_dsetup | output | 1 | Short data setup before write end |
| viol_rcycle | output | 1 | Short read cycle |
| viol_addr | output | 1 | Address moved inside a write overlap |

## Verification
Every output is one register away from the sampled pins, so output enables, read data and all four flags are due exactly one clock after the sample that causes them. Stored data shows up one sample later than a naive model would expect, because the commit happens at the edge where the overlap drops and a read on that same edge is served from the old contents. The bench drives pins on the falling edge, updates a behavioural model on the rising edge from the same pins, and compares on the next falling edge, so every expectation lines up with that single register stage. Read data is only compared on lanes that are enabled and have been written.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_model_pkg::*;
#(
  parameter int LANES   = 2,
  parameter bit DUAL_CS = 1'b1
) (
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output sram_mode_e       mode,
  output logic             wr_ovl,
  output logic             rd_act
);

  logic sel;
  logic no_lane;

  // Single-select variant treats the active-high select as always true
  assign sel     = ~cs_n & (DUAL_CS ? cs_hi : 1'b1);
  assign no_lane = &be_n;

  always_comb begin
    if (!sel || no_lane) begin
      mode = MODE_STBY;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_OFF;
    end
  end

  assign wr_ovl = (mode == MODE_WRITE);
  assign rd_act = (mode == MODE_READ) || (mode == MODE_OFF);

endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Read-first single clock: a read on the commit edge sees the old word
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sram_timing_mon.sv
module sram_timing_mon #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int TWP_MIN = 3,
  parameter int TDS_MIN = 2,
  parameter int TRC_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ovl,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              viol_wpulse,
  output logic              viol_dsetup,
  output logic              viol_rcycle,
  output logic              viol_addr
);

  localparam int MAX_A  = (TWP_MIN > TDS_MIN) ? TWP_MIN : TDS_MIN;
  localparam int MAX_M  = (MAX_A > TRC_MIN) ? MAX_A : TRC_MIN;
  localparam int CNT_W  = $clog2(MAX_M + 1) + 1;
  localparam logic [CNT_W-1:0] TWP_L = CNT_W'(TWP_MIN);
  localparam logic [CNT_W-1:0] TDS_L = CNT_W'(TDS_MIN);
  localparam logic [CNT_W-1:0] TRC_L = CNT_W'(TRC_MIN);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic              ovl_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [CNT_W-1:0]  wcnt;
  logic [CNT_W-1:0]  dcnt;
  logic [CNT_W-1:0]  rcnt;
  logic              ovl_end;
  logic              addr_moved;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  assign ovl_end    = ovl_q & ~wr_ovl;
  assign addr_moved = (addr != addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_q       <= 1'b0;
      rd_q        <= 1'b0;
      addr_q      <= '0;
      din_q       <= '0;
      wcnt        <= '0;
      dcnt        <= '0;
      rcnt        <= '0;
      viol_wpulse <= 1'b0;
      viol_dsetup <= 1'b0;
      viol_rcycle <= 1'b0;
      viol_addr   <= 1'b0;
    end else begin
      ovl_q  <= wr_ovl;
      rd_q   <= rd_act;
      addr_q <= addr;
      din_q  <= din;
      wcnt   <= wr_ovl ? (ovl_q ? bump(wcnt) : ONE) : '0;
      dcnt   <= (din == din_q) ? bump(dcnt) : ONE;
      rcnt   <= (rd_act && rd_q && !addr_moved) ? bump(rcnt) : ONE;
      viol_wpulse <= ovl_end && (wcnt < TWP_L);
      viol_dsetup <= ovl_end && (dcnt < TDS_L);
      viol_rcycle <= rd_act && rd_q && addr_moved && (rcnt < TRC_L);
      viol_addr   <= wr_ovl && ovl_q && addr_moved;
    end
  end

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
  import sram_model_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter bit DUAL_CS = 1'b1,
  parameter int TWP_MIN = 3,
  parameter int TDS_MIN = 2,
  parameter int TRC_MIN = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  cs_hi,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [DATA_W/8-1:0]   be_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     din,
  output logic [DATA_W-1:0]     dout,
  output logic [DATA_W/8-1:0]   dout_en,
  output logic                  viol_wpulse,
  output logic                  viol_dsetup,
  output logic                  viol_rcycle,
  output logic                  viol_addr
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = 8;

  sram_mode_e        mode;
  logic              wr_ovl;
  logic              rd_act;

  // History of the last sample inside a write overlap
  logic              ovl_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [LANES-1:0]  wbe_q;
  logic              commit;

  sram_mode_decode #(
    .LANES   (LANES),
    .DUAL_CS (DUAL_CS)
  ) u_decode (
    .cs_n   (cs_n),
    .cs_hi  (cs_hi),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .be_n   (be_n),
    .mode   (mode),
    .wr_ovl (wr_ovl),
    .rd_act (rd_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_q <= 1'b0;
    end else begin
      ovl_q <= wr_ovl;
    end
    waddr_q <= addr;
    wdat_q  <= din;
    wbe_q   <= be_n;
  end

  assign commit = ovl_q & ~wr_ovl & ~rst;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane_mem #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
      ) u_mem (
        .clk   (clk),
        .we    (commit & ~wbe_q[g]),
        .waddr (waddr_q),
        .wdata (wdat_q[g*LANE_W +: LANE_W]),
        .raddr (addr),
        .rdata (dout[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= '0;
    end else if (mode == MODE_READ) begin
      dout_en <= ~be_n;
    end else begin
      dout_en <= '0;
    end
  end

  sram_timing_mon #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TWP_MIN (TWP_MIN),
    .TDS_MIN (TDS_MIN),
    .TRC_MIN (TRC_MIN)
  ) u_mon (
    .clk         (clk),
    .rst         (rst),
    .wr_ovl      (wr_ovl),
    .rd_act      (rd_act),
    .addr        (addr),
    .din         (din),
    .viol_wpulse (viol_wpulse),
    .viol_dsetup (viol_dsetup),
    .viol_rcycle (viol_rcycle),
    .viol_addr   (viol_addr)
  );

endmodule

// File: rtl/sram_model_chk.sv
module sram_model_chk #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter bit DUAL_CS = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                cs_hi,
  input logic                we_n,
  input logic                oe_n,
  input logic [DATA_W/8-1:0] be_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W/8-1:0] dout_en,
  input logic                viol_wpulse,
  input logic                viol_dsetup,
  input logic                viol_rcycle,
  input logic                viol_addr
);

  logic picked;
  logic idle;
  logic ovl;

  assign picked = ~cs_n & (DUAL_CS ? cs_hi : 1'b1);
  assign idle   = ~picked | (&be_n);
  assign ovl    = ~idle & ~we_n;

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    idle |=> (dout_en == '0));

  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (picked && !we_n) |=> (dout_en == '0));

  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (!idle && we_n && !oe_n) |=> (dout_en == ~$past(be_n)));

  assert_outdis_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (picked && we_n && oe_n) |=> (dout_en == '0));

  assert_wpulse_after_end_R8: assert property (@(posedge clk) disable iff (rst)
    viol_wpulse |-> !$past(ovl));

  assert_dsetup_after_end_R9: assert property (@(posedge clk) disable iff (rst)
    viol_dsetup |-> !$past(ovl));

  assert_addr_move_R11: assert property (@(posedge clk) disable iff (rst)
    (ovl && $past(ovl) && (addr != $past(addr))) |=> viol_addr);

  assert_reset_clear_R12: assert property (@(posedge clk)
    rst |=> ((dout_en == '0) && !viol_wpulse && !viol_dsetup && !viol_rcycle && !viol_addr));

endmodule

bind async_sram_model sram_model_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .DUAL_CS (DUAL_CS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .cs_hi       (cs_hi),
  .we_n        (we_n),
  .oe_n        (oe_n),
  .be_n        (be_n),
  .addr        (addr),
  .dout_en     (dout_en),
  .viol_wpulse (viol_wpulse),
  .viol_dsetup (viol_dsetup),
  .viol_rcycle (viol_rcycle),
  .viol_addr   (viol_addr)
);

// File: tb/tb_async_sram_model.sv
module tb_async_sram_model;

  localparam int AW  = 10;
  localparam int TWP = 3;
  localparam int TDS = 2;
  localparam int TRC = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, cs_hi, we_n, oe_n;
  logic [1:0]  be_n;
  logic [AW-1:0] addr;
  logic [15:0] din;
  logic [15:0] dout, dout_sc;
  logic [1:0]  dout_en, dout_en_sc;
  logic        viol_wpulse, viol_dsetup, viol_rcycle, viol_addr;
  logic        sc_wp, sc_ds, sc_rc, sc_ad;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit armed  = 1'b0;
  string phase = "R3";

  always #10 clk = ~clk;

  async_sram_model #(.DATA_W(16), .ADDR_W(AW), .DUAL_CS(1'b1),
    .TWP_MIN(TWP), .TDS_MIN(TDS), .TRC_MIN(TRC)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_hi(cs_hi), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .viol_wpulse(viol_wpulse), .viol_dsetup(viol_dsetup),
    .viol_rcycle(viol_rcycle), .viol_addr(viol_addr));

  async_sram_model #(.DATA_W(16), .ADDR_W(AW), .DUAL_CS(1'b0),
    .TWP_MIN(TWP), .TDS_MIN(TDS), .TRC_MIN(TRC)) dut_sc (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_hi(cs_hi), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .din(din), .dout(dout_sc), .dout_en(dout_en_sc),
    .viol_wpulse(sc_wp), .viol_dsetup(sc_ds),
    .viol_rcycle(sc_rc), .viol_addr(sc_ad));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, updated from the pins at each rising edge
  logic [15:0] m_dat [int];
  logic [1:0]  m_kn  [int];
  logic [1:0]  e_en;
  logic [15:0] e_dat;
  logic [1:0]  e_kn;
  logic        e_wp, e_ds, e_rc, e_ad;
  string       en_tag, dat_tag;
  bit          p_ovl, p_rd;
  int          p_addr;
  logic [15:0] p_din;
  logic [1:0]  p_be;
  int          wlen, dlen, rlen;

  always @(posedge clk) begin
    bit sel, ovl, rd, rdo;
    sel = !cs_n && cs_hi && (be_n != 2'b11);
    ovl = sel && !we_n;
    rd  = sel && we_n;
    rdo = rd && !oe_n;
    armed <= 1'b1;
    dat_tag = phase;
    if (rst) begin
      e_en = 0; e_wp = 0; e_ds = 0; e_rc = 0; e_ad = 0; e_kn = 0;
      p_ovl = 0; p_rd = 0; p_addr = 0; p_din = 0; p_be = 2'b11;
      wlen = 0; dlen = 0; rlen = 0; en_tag = "R12";
    end else begin
      if (!sel) en_tag = "R1";
      else if (ovl) en_tag = "R2";
      else if (rdo) en_tag = "R3";
      else en_tag = "R4";
      e_wp = p_ovl && !ovl && (wlen < TWP);
      e_ds = p_ovl && !ovl && (dlen < TDS);
      e_rc = rd && p_rd && (int'(addr) != p_addr) && (rlen < TRC);
      e_ad = ovl && p_ovl && (int'(addr) != p_addr);
      e_en = rdo ? ~be_n : 2'b00;
      if (m_kn.exists(int'(addr))) begin
        e_dat = m_dat[int'(addr)];
        e_kn  = m_kn[int'(addr)];
      end else begin
        e_dat = 16'h0;
        e_kn  = 2'b00;
      end
      if (p_ovl && !ovl) begin
        if (!m_kn.exists(p_addr)) begin
          m_kn[p_addr] = 2'b00;
          m_dat[p_addr] = 16'h0;
        end
        if (!p_be[0]) begin m_dat[p_addr][7:0]  = p_din[7:0];  m_kn[p_addr][0] = 1'b1; end
        if (!p_be[1]) begin m_dat[p_addr][15:8] = p_din[15:8]; m_kn[p_addr][1] = 1'b1; end
      end
      wlen = ovl ? (p_ovl ? wlen + 1 : 1) : 0;
      dlen = (din == p_din) ? dlen + 1 : 1;
      rlen = (rd && p_rd && int'(addr) == p_addr) ? rlen + 1 : 1;
      p_ovl = ovl; p_rd = rd; p_addr = int'(addr); p_din = din; p_be = be_n;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(en_tag, "dout_en", {30'b0, dout_en}, {30'b0, e_en});
      if (e_en[0] && e_kn[0]) chk(dat_tag, "dout[7:0]", {24'b0, dout[7:0]}, {24'b0, e_dat[7:0]});
      if (e_en[1] && e_kn[1]) chk(dat_tag, "dout[15:8]", {24'b0, dout[15:8]}, {24'b0, e_dat[15:8]});
      chk("R8", "viol_wpulse", {31'b0, viol_wpulse}, {31'b0, e_wp});
      chk("R9", "viol_dsetup", {31'b0, viol_dsetup}, {31'b0, e_ds});
      chk("R10", "viol_rcycle", {31'b0, viol_rcycle}, {31'b0, e_rc});
      chk("R11", "viol_addr", {31'b0, viol_addr}, {31'b0, e_ad});
    end
  end

  task automatic drive(input logic cn, input logic ch, input logic wn, input logic on,
                       input logic [1:0] be, input int a, input logic [15:0] d, input int n);
    cs_n = cn; cs_hi = ch; we_n = wn; oe_n = on; be_n = be;
    addr = AW'(a); din = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic [1:0] be,
                    input int w, input logic on);
    drive(1'b0, 1'b1, 1'b0, on, be, a, d, w);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, a, d, 1);
  endtask

  task automatic rd(input int a, input logic [1:0] be, input int n);
    drive(1'b0, 1'b1, 1'b1, 1'b0, be, a, din, n);
  endtask

  initial begin
    rst = 1'b1;
    cs_n = 1'b1; cs_hi = 1'b0; we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    // R12: reset state on the ports
    chk("R12", "dout_en after reset", {30'b0, dout_en}, 32'h0);
    chk("R12", "flags after reset",
        {28'b0, viol_wpulse, viol_dsetup, viol_rcycle, viol_addr}, 32'h0);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 0, 16'h0, 2);

    phase = "R3";
    wr(5, 16'h1234, 2'b00, 4, 1'b1);
    rd(5, 2'b00, 3);
    wr(9, 16'hABCD, 2'b00, 4, 1'b1);
    phase = "R5";
    wr(9, 16'h55EF, 2'b10, 4, 1'b1);   // lower lane only -> ABEF
    rd(9, 2'b00, 3);
    wr(9, 16'h7700, 2'b01, 3, 1'b1);   // upper lane only -> 77EF
    rd(9, 2'b01, 3);
    rd(9, 2'b10, 3);
    // R4: output disabled
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 9, 16'h0, 3);
    // R2: write with output enable low
    phase = "R2";
    wr(12, 16'h0F0F, 2'b00, 3, 1'b0);
    rd(12, 2'b00, 3);
    // R1: three standby causes
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 12, 16'h0, 2);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 12, 16'h0, 2);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 12, 16'h0, 2);
    // R8: single-sample overlap
    wr(20, 16'h1111, 2'b00, 1, 1'b1);
    // R9: data changes on the final overlap sample
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 50, 16'hAAAA, 3);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 50, 16'hBBBB, 1);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 50, 16'hBBBB, 1);
    rd(50, 2'b00, 3);
    // R10: address held for one read sample
    rd(5, 2'b00, 1);
    rd(9, 2'b00, 3);
    // R11: address moves inside the overlap
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 30, 16'hC0C0, 2);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 31, 16'hC0C0, 2);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 31, 16'hC0C0, 1);
    rd(31, 2'b00, 3);
    // R6: read on the commit edge sees old data, next read sees new
    phase = "R6";
    wr(40, 16'h1111, 2'b00, 3, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 40, 16'hDEAD, 3);
    rd(40, 2'b00, 1);
    chk("R6", "read on commit edge", {16'b0, dout}, 32'h1111);
    rd(40, 2'b00, 1);
    chk("R6", "read after commit", {16'b0, dout}, 32'hDEAD);
    rd(40, 2'b00, 2);
    // R7: single-select variant ignores cs_hi
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 5, 16'h0, 1);
    chk("R7", "single-select dout_en", {30'b0, dout_en_sc}, 32'h3);
    chk("R7", "single-select data", {16'b0, dout_sc}, 32'h1234);
    chk("R7", "dual-select stays off", {30'b0, dout_en}, 32'h0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 0, 16'h0, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule